// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block chooses where each of the two ALU operands comes from in the execute stage of a five-stage in-order pipeline. An operand can be the value read from the register file, which travels in the decode/execute register. It can also be the ALU result of the instruction one stage ahead, held in the execute/memory register. The third source is the writeback value of the instruction two stages ahead, held in the memory/writeback register. The comparisons use register numbers that the pipeline carries forward with each instruction, so the decision is made entirely from execute-stage state.

For each operand, the block compares the operand's source register number with the destination register number of each older in-flight instruction. An older instruction counts as a producer only when it writes a register and its destination is not register zero. When both older instructions match, the younger one wins, so a chain of writes to one register delivers the latest value. The block is purely combinational. It has no clock and no handshake: its inputs are pipeline-register contents, and the stall logic of the surrounding pipeline decides when they change. It reports the select code of each operand and also drives the selected operand data.

Top module: `opfwd_unit`

## Requirements
- R1: When no qualifying producer matches an operand's source register, that operand's select code is 2'b00 and its operand output equals its register-file value.
- R2: When the execute/memory producer has write-enable set, a nonzero destination, and a destination equal to an operand's source register, that operand's select is 2'b10 and its output equals the execute/memory result.
- R3: When the memory/writeback producer has write-enable set, a nonzero destination, and a destination equal to an operand's source register, and R2 does not apply to that operand, the select is 2'b01 and the output equals the writeback value.
- R4: When both producers qualify for the same operand, the execute/memory producer is chosen (select 2'b10).
- R5: A producer whose write-enable is clear is never forwarded, whatever its destination number.
- R6: A producer whose destination is register 0 is never forwarded, even with write-enable set. An operand sourcing register 0 therefore always takes its register-file value.
- R7: Operands A and B are decided independently. When both source registers match the same producer, both are forwarded from it.
- R8: The select code 2'b11 is never produced.
- R9: The outputs depend only on the present inputs, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | Source register number of operand A (decode/execute register) |
| src_b_idx | input | 5 | Source register number of operand B (decode/execute register) |
| rf_a_data | input | 32 | Register-file value for operand A |
| rf_b_data | input | 32 | Register-file value for operand B |
| exm_wr_en | input | 1 | Execute/memory instruction writes a register |
| exm_dst_idx | input | 5 | Execute/memory destination register number |
| exm_result | input | 32 | Execute/memory ALU result |
| mwb_wr_en | input | 1 | Memory/writeback instruction writes a register |
| mwb_dst_idx | input | 5 | Memory/writeback destination register number |
| mwb_result | input | 32 | Memory/writeback value to be written |
| sel_a | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Operand B source, same encoding as sel_a |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
The bench steps through a chain of dependent writes to one register. In that chain both producers match, and a design with the priority reversed would hand the ALU the stale writeback value. Separate cases set a write-enable high with destination 0, and set a matching destination with write-enable low. A design that skips either guard would forward garbage into an operand that should read the register file. Cases where both operands hit the same producer, or different producers, expose logic that lets one operand's decision leak into the other. A pseudo-random sweep over a small register range is compared against a model written from the requirements, which reaches the mixed hit patterns.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  // Operand source code; the values are seen at the ports.
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
// Decides whether one producer stage qualifies for one source register.
module fwd_match #(
  parameter int IDX_W = 5
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] src_idx,
  output logic             hit
);
  logic dst_live;
  assign dst_live = wr_en && (dst_idx != '0);
  assign hit      = dst_live && (dst_idx == src_idx);
endmodule

// File: rtl/fwd_prio.sv
// Turns the two stage hits of one operand into a select code, newest first.
module fwd_prio
  import opfwd_pkg::*;
(
  input  logic     exm_hit,
  input  logic     mwb_hit,
  output fwd_sel_e sel
);
  always_comb begin
    if (exm_hit)      sel = FWD_EXM;
    else if (mwb_hit) sel = FWD_WB;
    else              sel = FWD_RF;
  end
endmodule

// File: rtl/fwd_mux.sv
// Three-way operand mux driven by a select code.
module fwd_mux
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] rf_data,
  input  logic [DATA_W-1:0] exm_data,
  input  logic [DATA_W-1:0] mwb_data,
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    unique case (sel)
      FWD_EXM: opnd = exm_data;
      FWD_WB:  opnd = mwb_data;
      default: opnd = rf_data;
    endcase
  end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
  import opfwd_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic [IDX_W-1:0]  src_b_idx,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  input  logic              exm_wr_en,
  input  logic [IDX_W-1:0]  exm_dst_idx,
  input  logic [DATA_W-1:0] exm_result,
  input  logic              mwb_wr_en,
  input  logic [IDX_W-1:0]  mwb_dst_idx,
  input  logic [DATA_W-1:0] mwb_result,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int N_OPND = 2;

  logic [IDX_W-1:0]  src_idx [N_OPND];
  logic [DATA_W-1:0] rf_data [N_OPND];
  fwd_sel_e          sel_v   [N_OPND];
  logic [DATA_W-1:0] opnd_v  [N_OPND];

  assign src_idx[0] = src_a_idx;
  assign src_idx[1] = src_b_idx;
  assign rf_data[0] = rf_a_data;
  assign rf_data[1] = rf_b_data;

  for (genvar op = 0; op < N_OPND; op++) begin : g_opnd
    logic exm_hit;
    logic mwb_hit;

    fwd_match #(.IDX_W(IDX_W)) u_exm_match (
      .wr_en  (exm_wr_en),
      .dst_idx(exm_dst_idx),
      .src_idx(src_idx[op]),
      .hit    (exm_hit)
    );

    fwd_match #(.IDX_W(IDX_W)) u_mwb_match (
      .wr_en  (mwb_wr_en),
      .dst_idx(mwb_dst_idx),
      .src_idx(src_idx[op]),
      .hit    (mwb_hit)
    );

    fwd_prio u_prio (
      .exm_hit(exm_hit),
      .mwb_hit(mwb_hit),
      .sel    (sel_v[op])
    );

    fwd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel     (sel_v[op]),
      .rf_data (rf_data[op]),
      .exm_data(exm_result),
      .mwb_data(mwb_result),
      .opnd    (opnd_v[op])
    );

    // Checks relating the select to the producer ports and the mux output.
    always_comb begin
      // R8: only the three legal codes appear
      p_legal_code_r8: assert (sel_v[op] != fwd_sel_e'(2'b11))
        else $error("illegal select code");
      // R6: a register-0 destination never feeds an operand
      p_zero_exm_r6: assert (!(exm_dst_idx == '0 && sel_v[op] == FWD_EXM))
        else $error("forwarded from register 0 (exm)");
      p_zero_mwb_r6: assert (!(mwb_dst_idx == '0 && sel_v[op] == FWD_WB))
        else $error("forwarded from register 0 (mwb)");
      // R5: a non-writing producer is never chosen
      p_no_we_r5: assert (!((!exm_wr_en && sel_v[op] == FWD_EXM) ||
                            (!mwb_wr_en && sel_v[op] == FWD_WB)))
        else $error("forwarded from non-writing producer");
      // R4: an older producer never wins over a qualifying younger one
      p_newest_r4: assert (!(sel_v[op] == FWD_WB && exm_wr_en &&
                             exm_dst_idx != '0 && exm_dst_idx == src_idx[op]))
        else $error("older producer preferred");
      // R2: the operand carries the execute/memory result when selected
      p_exm_data_r2: assert (!(sel_v[op] == FWD_EXM) || opnd_v[op] == exm_result)
        else $error("operand mismatch on exm select");
      // R1: an unforwarded operand carries its register-file value
      p_rf_data_r1: assert (!(sel_v[op] == FWD_RF) || opnd_v[op] == rf_data[op])
        else $error("operand mismatch on rf select");
    end
  end

  assign sel_a  = sel_v[0];
  assign sel_b  = sel_v[1];
  assign opnd_a = opnd_v[0];
  assign opnd_b = opnd_v[1];
endmodule

// File: tb/opfwd_unit_tb_top.sv
module opfwd_unit_tb_top;
  localparam int IDX_W  = 5;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [IDX_W-1:0]  src_a_idx, src_b_idx, exm_dst_idx, mwb_dst_idx;
  logic [DATA_W-1:0] rf_a_data, rf_b_data, exm_result, mwb_result;
  logic              exm_wr_en, mwb_wr_en;
  logic [1:0]        sel_a, sel_b;
  logic [DATA_W-1:0] opnd_a, opnd_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  opfwd_unit #(.IDX_W(IDX_W), .DATA_W(DATA_W)) dut_i (
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
    .exm_wr_en(exm_wr_en), .exm_dst_idx(exm_dst_idx), .exm_result(exm_result),
    .mwb_wr_en(mwb_wr_en), .mwb_dst_idx(mwb_dst_idx), .mwb_result(mwb_result),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  // Expected select from the requirements (00 rf, 10 exm, 01 mwb).
  function automatic logic [1:0] exp_sel(input logic [IDX_W-1:0] src);
    if (exm_wr_en && exm_dst_idx != 0 && exm_dst_idx == src) return 2'b10;
    if (mwb_wr_en && mwb_dst_idx != 0 && mwb_dst_idx == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DATA_W-1:0] exp_data(input logic [1:0] s,
                                                 input logic [DATA_W-1:0] rf);
    return (s == 2'b10) ? exm_result : (s == 2'b01) ? mwb_result : rf;
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Apply a producer/consumer setup at the falling edge, then sample 1 ns later.
  task automatic drive(input logic [IDX_W-1:0] sa, input logic [IDX_W-1:0] sb,
                       input logic ew, input logic [IDX_W-1:0] ed,
                       input logic mw, input logic [IDX_W-1:0] md);
    @(negedge clk);
    src_a_idx = sa; src_b_idx = sb;
    exm_wr_en = ew; exm_dst_idx = ed;
    mwb_wr_en = mw; mwb_dst_idx = md;
    #1;
  endtask

  task automatic check_both(input string req, input logic [1:0] ea, input logic [1:0] eb);
    check(req, sel_a, ea);
    check(req, opnd_a, exp_data(ea, rf_a_data));
    check(req, sel_b, eb);
    check(req, opnd_b, exp_data(eb, rf_b_data));
  endtask

  task automatic t_idle_r1;
    drive(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
    check_both("R1 idle", 2'b00, 2'b00);
    drive(5'd3, 5'd4, 1'b1, 5'd7, 1'b1, 5'd8);
    check_both("R1 no match", 2'b00, 2'b00);
  endtask

  task automatic t_exm_r2;
    drive(5'd9, 5'd4, 1'b1, 5'd9, 1'b0, 5'd0);
    check_both("R2 exm on A", 2'b10, 2'b00);
  endtask

  task automatic t_mwb_r3;
    drive(5'd4, 5'd12, 1'b1, 5'd5, 1'b1, 5'd12);
    check_both("R3 mwb on B", 2'b00, 2'b01);
  endtask

  // add r1,r1,r2 ; add r1,r1,r3 ; add r1,r1,r4 : third sees both producers.
  task automatic t_chain_r4;
    drive(5'd1, 5'd2, 1'b1, 5'd1, 1'b0, 5'd0);
    check_both("R4 chain step 2", 2'b10, 2'b00);
    drive(5'd1, 5'd4, 1'b1, 5'd1, 1'b1, 5'd1);
    check_both("R4 chain step 3 newest wins", 2'b10, 2'b00);
  endtask

  task automatic t_no_we_r5;
    drive(5'd6, 5'd6, 1'b0, 5'd6, 1'b0, 5'd6);
    check_both("R5 write-enable low", 2'b00, 2'b00);
    drive(5'd6, 5'd6, 1'b0, 5'd6, 1'b1, 5'd6);
    check_both("R5 exm off falls to mwb", 2'b01, 2'b01);
  endtask

  task automatic t_zero_r6;
    drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
    check_both("R6 zero destination", 2'b00, 2'b00);
    drive(5'd0, 5'd3, 1'b1, 5'd0, 1'b1, 5'd3);
    check_both("R6 zero exm, mwb to B", 2'b00, 2'b01);
  endtask

  task automatic t_indep_r7;
    drive(5'd11, 5'd11, 1'b1, 5'd11, 1'b0, 5'd0);
    check_both("R7 same producer both", 2'b10, 2'b10);
    drive(5'd13, 5'd14, 1'b1, 5'd14, 1'b1, 5'd13);
    check_both("R7 different producers", 2'b01, 2'b10);
  endtask

  // R9 and R8: the outputs follow new data with no clock edge involved.
  task automatic t_comb_r9;
    drive(5'd2, 5'd2, 1'b1, 5'd2, 1'b0, 5'd0);
    #0.5 exm_result = 32'hCAFE_0001;
    #0.5;
    check("R9 same-cycle data", opnd_a, 32'hCAFE_0001);
    check("R8 code legal", {31'd0, sel_b == 2'b11}, 32'd0);
  endtask

  task automatic t_sweep;
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive({3'b0, lfsr[1:0]}, {3'b0, lfsr[3:2]}, lfsr[4], {3'b0, lfsr[6:5]},
            lfsr[7], {3'b0, lfsr[9:8]});
      check_both("R1 R2 R3 R4 R5 R6 R7 sweep", exp_sel(src_a_idx), exp_sel(src_b_idx));
      check("R8 sweep", {31'd0, (sel_a == 2'b11) || (sel_b == 2'b11)}, 32'd0);
    end
  endtask

  initial begin
    src_a_idx = '0; src_b_idx = '0; exm_dst_idx = '0; mwb_dst_idx = '0;
    exm_wr_en = 1'b0; mwb_wr_en = 1'b0;
    rf_a_data = 32'hA0A0_0001; rf_b_data = 32'hB0B0_0002;
    exm_result = 32'hE0E0_0003; mwb_result = 32'hD0D0_0004;
    repeat (2) @(posedge clk);
    t_idle_r1();
    t_exm_r2();
    t_mwb_r3();
    t_chain_r4();
    t_no_we_r5();
    t_zero_r6();
    t_indep_r7();
    t_comb_r9();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule